// File: doc/BRIEF.md
# Fault blink pattern generator

This block drives an active-low open-drain fault pin so that an LED or a host can tell fault classes apart by their timing. Six fault status flags come in; the block picks the one of highest priority and plays that class's own loop of low and high phases on the pin. A drive value of 0 pulls the pin down, and a drive value of 1 releases it. Every phase is a whole number of time units. One unit is `UNIT_TICKS` pulses of a prescaled timebase tick. With the default of 83 pulses of a 1 ms tick, a unit is about 83 ms.

When the selected class changes, the new pattern starts again from its first phase, and that first phase runs its full length. When a routing input is set, the pin carries a speed pulse input in place of the fault pattern. The pin drive comes from a register, so every change on the pin lines up with a clock edge.

Top module: `fault_blink_top`

## Requirements
- R1: The pin is released (`pin_n` = 1) while reset is held, and also whenever no fault flag is active.
- R2: When several flags are active, one class is shown. The priority order, highest first, is: supply low, over-temperature, overcurrent, stall, overvoltage, demand low.
- R3: A stall fault holds the pin low without a break.
- R4: An overcurrent fault loops through 8 units released, then 8 units low.
- R5: An over-temperature fault loops through low 8, released 2, low 1, released 2, low 1, released 2 (in units).
- R6: A supply-low fault loops through low 1, released 1, low 1, released 13 (in units).
- R7: An overvoltage fault loops through 2 units released, then 2 units low.
- R8: A demand-low state loops through released 3, low 1, released 4, low 8 (in units).
- R9: One unit is exactly `UNIT_TICKS` clock cycles in which `tick_in` is high. Cycles in which `tick_in` is low do not advance the pattern.
- R10: When the flags select a new class at a clock edge, the pin shows that class's first phase from the following edge on. The first phase lasts its full length, and a class that was pre-empted does not resume mid-pattern when it comes back.
- R11: While `route_speed` is 1, `pin_n` equals the `speed_in` value sampled at the previous clock edge, and no fault pattern is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Prescaled timebase tick, one cycle wide |
| f_supply_low | input | 1 | Supply undervoltage flag (highest priority) |
| f_overtemp | input | 1 | Thermal shutdown flag |
| f_overcurrent | input | 1 | Overcurrent flag |
| f_stall | input | 1 | Rotor lock / stall flag |
| f_overvolt | input | 1 | Overvoltage flag |
| f_demand_low | input | 1 | Demand below on-threshold flag (lowest priority) |
| route_speed | input | 1 | 1: pin carries `speed_in` instead of the fault pattern |
| speed_in | input | 1 | Speed pulse to be passed through |
| pin_n | output | 1 | Pin drive: 0 pulls the pin low, 1 releases it |

## Verification
All 64 combinations of the six flags are applied, each after a return to idle. Over a little more than one full period of the winning class, the pin is compared cycle by cycle with a model built from the phase lists. This separates a wrong priority, a wrong phase length or level, and a wrong loop point. A sparse tick stream and a stopped tick show that the pattern advances on ticks and not on clock cycles. Pre-empting overcurrent with supply low, and then dropping supply low, shows that each class restarts from its first phase instead of resuming. An irregular bit stream on the speed input with routing enabled, while a fault is active, shows the pass-through and its one-cycle delay.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  localparam int N_FAULT   = 6;
  localparam int SEG_LEN_W = 4;
  localparam int SEG_IDX_W = 3;

  // class code k+1 belongs to flag k of the priority-ordered flag vector
  typedef enum logic [2:0] {
    CLS_NONE     = 3'd0,
    CLS_SUPPLY   = 3'd1,
    CLS_OVERTEMP = 3'd2,
    CLS_OVERCUR  = 3'd3,
    CLS_STALL    = 3'd4,
    CLS_OVERVOLT = 3'd5,
    CLS_DEMAND   = 3'd6
  } fault_cls_e;

  // one phase: pin level, length in units, loop point flag
  typedef struct packed {
    logic                 lvl;
    logic [SEG_LEN_W-1:0] len;
    logic                 last;
  } seg_t;

  function automatic seg_t mk(logic l, int n, logic e);
    seg_t s;
    s.lvl  = l;
    s.len  = SEG_LEN_W'(n);
    s.last = e;
    return s;
  endfunction

  function automatic seg_t seg_lookup(fault_cls_e c, logic [SEG_IDX_W-1:0] i);
    seg_t s;
    s = mk(1'b1, 1, 1'b1);
    case (c)
      CLS_SUPPLY: begin
        case (i)
          3'd0:    s = mk(1'b0, 1, 1'b0);
          3'd1:    s = mk(1'b1, 1, 1'b0);
          3'd2:    s = mk(1'b0, 1, 1'b0);
          default: s = mk(1'b1, 13, 1'b1);
        endcase
      end
      CLS_OVERTEMP: begin
        case (i)
          3'd0:    s = mk(1'b0, 8, 1'b0);
          3'd1:    s = mk(1'b1, 2, 1'b0);
          3'd2:    s = mk(1'b0, 1, 1'b0);
          3'd3:    s = mk(1'b1, 2, 1'b0);
          3'd4:    s = mk(1'b0, 1, 1'b0);
          default: s = mk(1'b1, 2, 1'b1);
        endcase
      end
      CLS_OVERCUR: begin
        if (i == 3'd0) s = mk(1'b1, 8, 1'b0);
        else           s = mk(1'b0, 8, 1'b1);
      end
      CLS_STALL:     s = mk(1'b0, 1, 1'b1);
      CLS_OVERVOLT: begin
        if (i == 3'd0) s = mk(1'b1, 2, 1'b0);
        else           s = mk(1'b0, 2, 1'b1);
      end
      CLS_DEMAND: begin
        case (i)
          3'd0:    s = mk(1'b1, 3, 1'b0);
          3'd1:    s = mk(1'b0, 1, 1'b0);
          3'd2:    s = mk(1'b1, 4, 1'b0);
          default: s = mk(1'b0, 8, 1'b1);
        endcase
      end
      default:       s = mk(1'b1, 1, 1'b1);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fbp_picker.sv
module fbp_picker
  import fbp_pkg::*;
#(
  parameter int N = N_FAULT
) (
  input  logic [N-1:0] req,
  output fault_cls_e   pick
);
  // lowest index wins; walk from the bottom of the order upward
  always_comb begin
    pick = CLS_NONE;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) pick = fault_cls_e'(k + 1);
    end
  end
endmodule

// File: rtl/fbp_unit_timer.sv
module fbp_unit_timer #(
  parameter int UNIT_TICKS = 83
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  output logic unit_stb
);
  localparam int CW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(UNIT_TICKS - 1);

  logic [CW-1:0] cnt;

  assign unit_stb = tick && (cnt == LAST) && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fbp_sequencer.sv
module fbp_sequencer
  import fbp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  fault_cls_e           pick,
  input  logic                 unit_stb,
  output fault_cls_e           cls_q,
  output logic [SEG_IDX_W-1:0] seg_idx,
  output logic [SEG_LEN_W-1:0] seg_cnt,
  output logic                 restart,
  output logic                 level
);
  seg_t cur;

  assign cur     = seg_lookup(cls_q, seg_idx);
  assign restart = (pick != cls_q);
  assign level   = cur.lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_q   <= CLS_NONE;
      seg_idx <= '0;
      seg_cnt <= '0;
    end else if (restart) begin
      cls_q   <= pick;
      seg_idx <= '0;
      seg_cnt <= '0;
    end else if (unit_stb) begin
      if (seg_cnt == cur.len - 1'b1) begin
        seg_cnt <= '0;
        seg_idx <= cur.last ? '0 : seg_idx + 1'b1;
      end else begin
        seg_cnt <= seg_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fault_blink_top.sv
module fault_blink_top
  import fbp_pkg::*;
#(
  parameter int UNIT_TICKS = 83
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  input  logic f_supply_low,
  input  logic f_overtemp,
  input  logic f_overcurrent,
  input  logic f_stall,
  input  logic f_overvolt,
  input  logic f_demand_low,
  input  logic route_speed,
  input  logic speed_in,
  output logic pin_n
);
  logic [N_FAULT-1:0]   req;
  fault_cls_e           pick;
  fault_cls_e           seq_cls;
  logic [SEG_IDX_W-1:0] seg_idx;
  logic [SEG_LEN_W-1:0] seg_cnt;
  logic                 restart;
  logic                 unit_stb;
  logic                 level;

  // index order is priority order
  assign req = {f_demand_low, f_overvolt, f_stall,
                f_overcurrent, f_overtemp, f_supply_low};

  fbp_picker #(.N(N_FAULT)) u_pick (
    .req  (req),
    .pick (pick)
  );

  fbp_unit_timer #(.UNIT_TICKS(UNIT_TICKS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_in),
    .clear    (restart),
    .unit_stb (unit_stb)
  );

  fbp_sequencer u_seq (
    .clk      (clk),
    .rst      (rst),
    .pick     (pick),
    .unit_stb (unit_stb),
    .cls_q    (seq_cls),
    .seg_idx  (seg_idx),
    .seg_cnt  (seg_cnt),
    .restart  (restart),
    .level    (level)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_n <= 1'b1;
    else     pin_n <= route_speed ? speed_in : level;
  end
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker
  import fbp_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 tick_in,
  input logic [N_FAULT-1:0]   flags,
  input logic                 route_speed,
  input logic                 speed_in,
  input logic                 pin_n,
  input fault_cls_e           seq_cls,
  input logic [SEG_IDX_W-1:0] seg_idx,
  input logic [SEG_LEN_W-1:0] seg_cnt
);
  // R1: no flags seen two edges back and no routing -> released
  a_r1_idle_release: assert property (@(posedge clk) disable iff (rst)
    ($past(flags == '0, 2) && !$past(route_speed)) |-> pin_n);

  // R3: stall as the winning class -> pin held low
  a_r3_stall_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(flags[3:0] == 4'b1000, 2)
     && !$past(route_speed)) |-> !pin_n);

  // R2: supply-low flag always wins the selection
  a_r2_supply_first: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flags[0])) |-> (seq_cls == CLS_SUPPLY));

  // R10: a class change lands on the first phase with a fresh count
  a_r10_restart_first: assert property (@(posedge clk) disable iff (rst)
    !$stable(seq_cls) |-> (seg_idx == '0 && seg_cnt == '0));

  // R9: an edge without a tick leaves the phase position alone
  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick_in) && $stable(seq_cls))
    |-> ($stable(seg_cnt) && $stable(seg_idx)));

  // R11: routed pin follows the speed input one edge later
  a_r11_route_follow: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(route_speed)) |-> (pin_n == $past(speed_in)));
endmodule

bind fault_blink_top fbp_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_in     (tick_in),
  .flags       ({f_demand_low, f_overvolt, f_stall,
                 f_overcurrent, f_overtemp, f_supply_low}),
  .route_speed (route_speed),
  .speed_in    (speed_in),
  .pin_n       (pin_n),
  .seq_cls     (seq_cls),
  .seg_idx     (seg_idx),
  .seg_cnt     (seg_cnt)
);

// File: tb/test_fault_blink_top.sv
module test_fault_blink_top;
  localparam int UNIT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_in = 1'b0;
  logic [5:0] flags = '0;
  logic       route = 1'b0;
  logic       spd = 1'b0;
  logic       pin_n;
  int         tick_gap = 1;
  int         n_tests = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  fault_blink_top #(.UNIT_TICKS(UNIT)) i_fault_blink_top (
    .clk           (clk),
    .rst           (rst),
    .tick_in       (tick_in),
    .f_supply_low  (flags[0]),
    .f_overtemp    (flags[1]),
    .f_overcurrent (flags[2]),
    .f_stall       (flags[3]),
    .f_overvolt    (flags[4]),
    .f_demand_low  (flags[5]),
    .route_speed   (route),
    .speed_in      (spd),
    .pin_n         (pin_n)
  );

  // tick stream: one pulse every tick_gap cycles
  initial begin
    int ctr;
    ctr = 0;
    forever begin
      @(negedge clk);
      ctr++;
      if (ctr >= tick_gap) ctr = 0;
      tick_in = (ctr == 0);
    end
  end

  // class 0 = none, else 1 + index of the highest-priority flag (R2)
  function automatic int cls_of(logic [5:0] f);
    for (int k = 0; k < 6; k++) if (f[k]) return k + 1;
    return 0;
  endfunction

  function automatic int seg_len(int c, int i);
    int t[6];
    case (c)
      1:       t = '{1, 1, 1, 13, 0, 0};
      2:       t = '{8, 2, 1, 2, 1, 2};
      3:       t = '{8, 8, 0, 0, 0, 0};
      5:       t = '{2, 2, 0, 0, 0, 0};
      6:       t = '{3, 1, 4, 8, 0, 0};
      default: t = '{1, 0, 0, 0, 0, 0};
    endcase
    return (i < 6) ? t[i] : 0;
  endfunction

  // phases alternate; these classes begin released
  function automatic bit first_lvl(int c);
    return (c == 0) || (c == 3) || (c == 5) || (c == 6);
  endfunction

  function automatic bit exp_lvl(int c, int u);
    int per;
    int acc;
    per = 0;
    for (int i = 0; seg_len(c, i) > 0; i++) per += seg_len(c, i);
    u = u % per;
    acc = 0;
    for (int i = 0; seg_len(c, i) > 0; i++) begin
      acc += seg_len(c, i);
      if (u < acc) return first_lvl(c) ^ bit'(i % 2);
    end
    return 1'b1;
  endfunction

  function automatic string req_of(int c);
    case (c)
      1:       return "R6";
      2:       return "R5";
      3:       return "R4";
      4:       return "R3";
      5:       return "R7";
      6:       return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic check(bit exp, string tag, string what);
    n_tests++;
    if (pin_n !== exp) begin
      n_fail++;
      $display("FAIL %s %s: pin_n=%b expected %b (t=%0t)", tag, what, pin_n, exp, $time);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    flags = '0;
    repeat (3) @(posedge clk);
  endtask

  // apply flags, then compare every cycle against the phase model (R10 timing)
  task automatic play(logic [5:0] f, int ncyc, string what);
    int  c;
    int  ticks;
    bit  t;
    @(negedge clk);
    flags = f;
    c = cls_of(f);
    @(posedge clk);
    ticks = 0;
    for (int m = 1; m <= ncyc; m++) begin
      @(posedge clk);
      t = tick_in;
      #1;
      check(exp_lvl(c, ticks / UNIT), req_of(c), what);
      if (t) ticks++;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 check(1'b1, "R1", "during reset");
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      #1 check(1'b1, "R1", "idle after reset");
    end

    // R2..R8: every flag combination, one period and more
    for (int v = 0; v < 64; v++) begin
      idle();
      play(v[5:0], 52, "R2 flag sweep");
    end

    // R9: sparse and stopped tick
    tick_gap = 3;
    idle();
    play(6'b000010, 170, "R9 sparse tick overtemp");
    idle();
    play(6'b100000, 160, "R9 sparse tick demand");
    tick_gap = 1000;
    idle();
    play(6'b000100, 40, "R9 stopped tick");
    tick_gap = 1;

    // R10: pre-emption and restart
    idle();
    play(6'b000100, 30, "R10 overcurrent alone");
    play(6'b000101, 30, "R10 supply pre-empts");
    play(6'b000100, 30, "R10 overcurrent restarts");

    // R11: speed routing with a fault active
    idle();
    for (int k = 0; k < 40; k++) begin
      bit s;
      @(negedge clk);
      flags = 6'b000010;
      route = 1'b1;
      spd = ((k % 3) == 0) ^ ((k % 5) == 0);
      @(posedge clk);
      s = spd;
      #1 check(s, "R11", "routed speed pulse");
    end
    @(negedge clk);
    route = 1'b0;
    idle();
    #1 check(1'b1, "R1", "release after routing");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule